// File: doc/BRIEF.md
# Per-Rank Extended Mode Register Write Sequencer

This block sends extended mode register writes to a memory array made of several ranks. Each rank gets its own write, so each rank can carry its own partial-array self-refresh setting. The block keeps one 13-bit configuration word per chip select, loaded through a small write port.

Each rising edge of a software trigger sends one mode register set command. The command goes to the rank that the internal pointer names, and the pointer then moves on. The first trigger after reset targets rank 0. Later triggers target ranks 1, 2 and 3, and then the pointer wraps back to 0.

A mobile-mode enable selects the bank address used for the extended register. When it is clear, the standard DDR/SDR bank address is used. After each command a busy flag stays high for a programmable number of mode-register cycles, and triggers are ignored until it drops. The block does not check whether later accesses fall inside the refresh region that a word configures.

Top module: `mrs_rank_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `cmd_valid` reads 0, `cmd_cs_n` is all ones and `busy` is 0. The rank pointer returns to rank 0 and every stored word is cleared to zero.
- R2: With `cfg_we` high at a clock edge, `cfg_data` is stored as the word of rank `cfg_sel`. Each command drives the stored word of its target rank on `cmd_addr`.
- R3: During a command cycle, exactly one bit of `cmd_cs_n` is low, and bit k low means rank k. Outside command cycles `cmd_cs_n` is all ones. The first command after reset selects rank 0.
- R4: Successive commands target ranks 0, 1, 2, 3 in order, then wrap to 0.
- R5: `cmd_ba` is 2'b10 when `mobile_en` was high at the triggering edge, and 2'b01 when it was low.
- R6: A command starts on a 0-to-1 transition of `trigger` sampled at a clock edge. `cmd_valid` rises in the cycle after that edge and lasts exactly one cycle. Holding `trigger` high issues no further command.
- R7: `busy` rises together with `cmd_valid` and stays high for `mrd_cycles`+1 cycles in total, using the value of `mrd_cycles` at the triggering edge.
- R8: A rising edge of `trigger` while `busy` is high is ignored. No command is issued, the pointer does not advance, and a trigger still held when busy drops issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mobile_en | input | 1 | Selects mobile-style bank address for the extended register |
| cfg_we | input | 1 | Stores cfg_data into the selected rank word |
| cfg_sel | input | PW (2) | Rank whose word is written |
| cfg_data | input | AW (13) | Extended mode register word |
| mrd_cycles | input | DW (8) | Busy hold cycles after each command |
| trigger | input | 1 | Software trigger, edge detected |
| cmd_valid | output | 1 | One-cycle mode register set command strobe |
| cmd_ba | output | 2 | Bank address of the command |
| cmd_addr | output | AW (13) | Address bus carrying the rank word |
| cmd_cs_n | output | RANKS (4) | Active-low chip selects, one low during a command |
| busy | output | 1 | Command in progress, triggers ignored |

## Verification
The assertions check the command shape on every cycle:
- exactly one chip select during a command and none outside it;
- the selected rank matches the pointer before the edge;
- the bank address follows the mobile bit sampled at the edge;
- the command strobe lasts one cycle, with busy high alongside it;
- no command starts in a cycle that follows a busy cycle.

Only the bench scenarios can show the remaining behaviour:
- the stored words reaching the address bus;
- the exact length of the busy window for each delay value;
- the wrap from rank 3 back to 0;
- that a trigger held past the end of busy stays ignored;
- that a reset in the middle of a sequence restarts at rank 0 with cleared words.

// File: rtl/mrs_rank_seq.sv
module mrs_rank_seq #(
  parameter int RANKS = 4,
  parameter int AW    = 13,
  parameter int DW    = 8,
  localparam int PW   = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mobile_en,
  input  logic             cfg_we,
  input  logic [PW-1:0]    cfg_sel,
  input  logic [AW-1:0]    cfg_data,
  input  logic [DW-1:0]    mrd_cycles,
  input  logic             trigger,
  output logic             cmd_valid,
  output logic [1:0]       cmd_ba,
  output logic [AW-1:0]    cmd_addr,
  output logic [RANKS-1:0] cmd_cs_n,
  output logic             busy
);

  localparam logic [1:0] BA_MOBILE = 2'b10;
  localparam logic [1:0] BA_STD    = 2'b01;

  logic [AW-1:0] word [RANKS];
  logic [PW-1:0] ptr;
  logic [DW-1:0] cnt;
  logic          trig_q;
  logic          fire;

  assign fire = trigger & ~trig_q & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RANKS; i++) word[i] <= '0;
    end else if (cfg_we && int'(cfg_sel) < RANKS) begin
      word[cfg_sel] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q    <= 1'b0;
      ptr       <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_ba    <= '0;
      cmd_addr  <= '0;
      cmd_cs_n  <= '1;
    end else begin
      trig_q    <= trigger;
      cmd_valid <= fire;
      if (fire) begin
        cmd_ba   <= mobile_en ? BA_MOBILE : BA_STD;
        cmd_addr <= word[ptr];
        cmd_cs_n <= ~(RANKS'(1) << ptr);
        ptr      <= (ptr == PW'(RANKS - 1)) ? '0 : ptr + PW'(1);
        cnt      <= mrd_cycles;
        busy     <= 1'b1;
      end else begin
        cmd_cs_n <= '1;
        if (busy) begin
          if (cnt == '0) busy <= 1'b0;
          else           cnt  <= cnt - DW'(1);
        end
      end
    end
  end

endmodule

module mrs_rank_seq_chk #(
  parameter int RANKS = 4,
  parameter int PW    = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             mobile_en,
  input logic             cmd_valid,
  input logic [1:0]       cmd_ba,
  input logic [RANKS-1:0] cmd_cs_n,
  input logic             busy,
  input logic [PW-1:0]    ptr
);

  a_r3_cs_onehot: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $countones(~cmd_cs_n) == 1);

  a_r3_cs_idle: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> &cmd_cs_n);

  a_r4_rank_from_ptr: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !cmd_cs_n[$past(ptr)]);

  a_r5_bank_addr: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_ba == ($past(mobile_en) ? 2'b10 : 2'b01));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  a_r7_busy_with_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy);

  a_r8_no_cmd_after_busy: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> !cmd_valid);

endmodule

bind mrs_rank_seq mrs_rank_seq_chk #(.RANKS(RANKS), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .mobile_en(mobile_en), .cmd_valid(cmd_valid),
  .cmd_ba(cmd_ba), .cmd_cs_n(cmd_cs_n), .busy(busy), .ptr(ptr)
);

// File: tb/mrs_rank_seq_test.sv
`timescale 1ns/1ps
module mrs_rank_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mobile_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [12:0] cfg_data = '0;
  logic [7:0]  mrd_cycles = '0;
  logic        trigger = 1'b0;
  logic        cmd_valid;
  logic [1:0]  cmd_ba;
  logic [12:0] cmd_addr;
  logic [3:0]  cmd_cs_n;
  logic        busy;

  int checks = 0;
  int fails = 0;
  logic [12:0] mw [4];
  int exp_rank = 0;

  always #5 clk = ~clk;

  mrs_rank_seq uut (
    .clk(clk), .rst(rst), .mobile_en(mobile_en), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .mrd_cycles(mrd_cycles),
    .trigger(trigger), .cmd_valid(cmd_valid), .cmd_ba(cmd_ba),
    .cmd_addr(cmd_addr), .cmd_cs_n(cmd_cs_n), .busy(busy)
  );

  function automatic logic [1:0] exp_ba(input logic mob);
    return mob ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [3:0] exp_cs(input int r);
    return ~(4'b0001 << r);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input int r, input logic [12:0] d);
    cfg_we = 1'b1; cfg_sel = 2'(r); cfg_data = d;
    tick();
    cfg_we = 1'b0;
    mw[r] = d;
  endtask

  task automatic fire_check(input logic mob, input logic [7:0] mrd, input bit hold);
    int n;
    int extra;
    mobile_en = mob; mrd_cycles = mrd; trigger = 1'b1;
    tick();
    mobile_en = ~mob; mrd_cycles = mrd + 8'd3;
    check(cmd_valid == 1'b1, "R6", "cmd_valid", int'(cmd_valid), 1);
    check(cmd_cs_n == exp_cs(exp_rank), "R3 R4", "cs_n", int'(cmd_cs_n), int'(exp_cs(exp_rank)));
    check(cmd_addr == mw[exp_rank], "R2", "addr", int'(cmd_addr), int'(mw[exp_rank]));
    check(cmd_ba == exp_ba(mob), "R5", "ba", int'(cmd_ba), int'(exp_ba(mob)));
    if (!hold) trigger = 1'b0;
    n = 0; extra = 0;
    while (busy && n < 400) begin
      n++;
      tick();
      if (cmd_valid) extra++;
    end
    check(n == int'(mrd) + 1, "R7", "busy cycles", n, int'(mrd) + 1);
    for (int k = 0; k < 3; k++) begin
      tick();
      if (cmd_valid) extra++;
    end
    check(extra == 0, "R6", "extra cmds", extra, 0);
    trigger = 1'b0;
    tick();
    exp_rank = (exp_rank + 1) % 4;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int extra;
    void'($urandom(32'h1234_abcd));
    for (int i = 0; i < 4; i++) mw[i] = '0;
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check(cmd_valid == 1'b0, "R1", "cmd_valid", int'(cmd_valid), 0);
    check(cmd_cs_n == 4'hF, "R1", "cs_n", int'(cmd_cs_n), 15);
    check(busy == 1'b0, "R1", "busy", int'(busy), 0);

    // R2 R3 R4: directed walk with wrap, standard then mobile
    cfg_write(0, 13'h0011); cfg_write(1, 13'h0A22);
    cfg_write(2, 13'h1F33); cfg_write(3, 13'h1FFF);
    for (int i = 0; i < 5; i++) fire_check(1'b0, 8'd2, 1'b0);
    fire_check(1'b1, 8'd0, 1'b1);   // R6 held trigger, zero delay
    fire_check(1'b1, 8'd0, 1'b0);

    // R8: trigger edges while busy are ignored
    mrd_cycles = 8'd6; trigger = 1'b1;
    tick();
    check(cmd_valid == 1'b1, "R8", "setup cmd", int'(cmd_valid), 1);
    trigger = 1'b0; tick();
    trigger = 1'b1; tick();
    extra = 0;
    for (int k = 0; k < 12; k++) begin
      if (cmd_valid) extra++;
      tick();
    end
    check(extra == 0, "R8", "cmds while busy/held", extra, 0);
    check(busy == 1'b0, "R8", "busy ended", int'(busy), 0);
    trigger = 1'b0; tick();
    exp_rank = (exp_rank + 1) % 4;
    fire_check(1'b0, 8'd1, 1'b0);   // R8 pointer advanced only once

    // random mix
    for (int it = 0; it < 40; it++) begin
      if ($urandom_range(0, 1) == 1) cfg_write(int'($urandom_range(0, 3)), 13'($urandom));
      fire_check(1'($urandom_range(0, 1)), 8'($urandom_range(0, 9)), 1'($urandom_range(0, 1)));
    end

    // R1 reset mid-sequence
    fire_check(1'b0, 8'd0, 1'b0);
    mrd_cycles = 8'd20; trigger = 1'b1; tick();
    rst = 1'b1; trigger = 1'b0; tick();
    check(cmd_cs_n == 4'hF, "R1", "cs_n in reset", int'(cmd_cs_n), 15);
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    rst = 1'b0; tick();
    for (int i = 0; i < 4; i++) mw[i] = '0;
    exp_rank = 0;
    fire_check(1'b1, 8'd3, 1'b0);   // R1 rank 0, cleared word

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule